// File: doc/BRIEF.md
# NAND Flash Interface Controller

This block sits between a simple register-access host port and a raw 8-bit NAND flash device. Software programs a configuration register with an enable bit, the flash chip-enable level and three clock-count timing fields. It then writes a command register, an address register or a data register. Each of those writes produces exactly one bus cycle on the flash pins. A read of the data register produces one read-strobe cycle and returns the captured byte.

Every flash cycle has three phases: a setup phase, a strobe phase and a hold phase. The latch signals are valid during setup, the active-low strobe is asserted during the strobe phase, and the latch signals stay valid through hold. The latch signals depend on which register offset was accessed. While a flash cycle runs, the host port holds a wait signal high, so that cycles never overlap. A status register exposes the flash ready/busy pin. A configuration bit gives a single-clock pulse that a separate error-correction block can use to clear its accumulator.

Top module: `nand_flash_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x00000B77: enable clear, chip-enable bit 11 set, setup field (bits 10:8) 3, strobe field (bits 6:4) 7, hold field (bits 2:0) 7. After reset `fl_ce_n`, `fl_we_n` and `fl_re_n` are 1, `fl_cle`, `fl_ale`, `fl_dq_oe`, `ecc_clear` and `host_wait` are 0, and `host_rdata` is 0.
- R2: A write to offset 0x04 (command) drives `fl_cle`=1 and `fl_ale`=0 for the whole flash cycle, and drives `host_wdata[7:0]` on `fl_dq_o` with `fl_dq_oe`=1.
- R3: A write to offset 0x08 (address) drives `fl_ale`=1 and `fl_cle`=0 for the whole cycle, and drives the byte as in R2.
- R4: A flash cycle consists of setup+1 clocks with both strobes high, then strobe+1 clocks with the strobe low, then hold+1 clocks with both strobes high. `host_wait` is high for all of these clocks and low at every other time. A field value of 0 means one clock.
- R5: While configuration bit 15 (enable) is 0, accesses to offsets 0x04, 0x08 and 0x0C start no flash cycle and `host_wait` stays low. A data read in this state returns 0.
- R6: `fl_ce_n` follows configuration bit 11 from the clock after the configuration write.
- R7: A configuration write with bit 12 set raises `ecc_clear` for exactly one clock after the write. Bit 12 always reads back as 0.
- R8: A read of offset 0x0C drives `fl_re_n` low for the strobe phase, with `fl_cle`=`fl_ale`=0 and `fl_dq_oe`=0. It samples `fl_dq_i` on the last strobe clock, and `host_rdata` holds that byte zero-extended when `host_wait` falls.
- R9: A read of offset 0x10 (status) returns `fl_rdy` in bit 0 (1 = ready) and 0 in all other bits on the next clock.
- R10: A host request made while `host_wait` is high is ignored and starts no extra flash cycle.
- R11: A write to offset 0x0C (data) produces a cycle with `fl_cle`=`fl_ale`=0 and `fl_we_n` as the strobe. The byte is driven on `fl_dq_o` with `fl_dq_oe`=1 for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host access request, taken on a clock where `host_wait` is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Byte offset of the register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, registered |
| host_wait | output | 1 | High while a flash cycle is running |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_dq_o | output | 8 | Byte driven toward the flash |
| fl_dq_oe | output | 1 | Output enable for `fl_dq_o` |
| fl_dq_i | input | 8 | Byte from the flash |
| fl_rdy | input | 1 | Flash ready/busy, 1 = ready |
| ecc_clear | output | 1 | One-clock pulse that clears an external ECC accumulator |

## Verification
Configuration and status reads update `host_rdata` on the clock edge that accepts them, so the bench reads them at the next falling edge. `fl_ce_n` and `ecc_clear` change on that same accepting edge. A flash cycle begins on the clock after acceptance and lasts (setup+1)+(strobe+1)+(hold+1) clocks. The captured read byte appears in `host_rdata` in the first clock with `host_wait` low. A monitor samples the pins on every falling edge and counts the clocks spent in each phase. When `host_wait` falls, it compares the completed cycle with the entry that the driver queued. The bench checks the single-clock results at the falling edge right after the accepting edge.

// File: rtl/nand_flash_pkg.sv
// Shared definitions for the NAND flash controller: register offsets,
// configuration bit positions and the flash cycle phase type.
package nand_flash_pkg;

    localparam int OFS_W = 5;
    localparam int TIM_W = 3;

    localparam logic [OFS_W-1:0] OFS_CFG  = 5'h00;
    localparam logic [OFS_W-1:0] OFS_CMD  = 5'h04;
    localparam logic [OFS_W-1:0] OFS_ADR  = 5'h08;
    localparam logic [OFS_W-1:0] OFS_DAT  = 5'h0C;
    localparam logic [OFS_W-1:0] OFS_STAT = 5'h10;

    localparam int BIT_EN    = 15;
    localparam int BIT_ECC   = 12;
    localparam int BIT_CE_N  = 11;
    localparam int LSB_SETUP = 8;
    localparam int LSB_PULSE = 4;
    localparam int LSB_HOLD  = 0;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef struct packed {
        logic [TIM_W-1:0] setup;
        logic [TIM_W-1:0] pulse;
        logic [TIM_W-1:0] hold;
    } timing_t;

endpackage

// File: rtl/nand_cfg_regs.sv
// Configuration register of the NAND controller.
// Holds the enable bit, the chip-enable level and three timing fields
// (each is the clock count minus one). It also produces the self-clearing
// ECC clear pulse. Assumes DATA_W > 16, so that all field bits exist.
module nand_cfg_regs
    import nand_flash_pkg::*;
#(
    parameter int               DATA_W    = 32,
    parameter logic [TIM_W-1:0] RST_SETUP = 3'd3,
    parameter logic [TIM_W-1:0] RST_PULSE = 3'd7,
    parameter logic [TIM_W-1:0] RST_HOLD  = 3'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              en,
    output logic              ce_n,
    output timing_t           timing,
    output logic              ecc_pulse,
    output logic [DATA_W-1:0] rd_value
);

    logic    en_q;
    logic    ce_n_q;
    logic    ecc_q;
    timing_t tim_q;

    // Register the configuration fields on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q        <= 1'b0;
            ce_n_q      <= 1'b1;
            tim_q.setup <= RST_SETUP;
            tim_q.pulse <= RST_PULSE;
            tim_q.hold  <= RST_HOLD;
        end else if (wr_en) begin
            en_q        <= wdata[BIT_EN];
            ce_n_q      <= wdata[BIT_CE_N];
            tim_q.setup <= wdata[LSB_SETUP +: TIM_W];
            tim_q.pulse <= wdata[LSB_PULSE +: TIM_W];
            tim_q.hold  <= wdata[LSB_HOLD  +: TIM_W];
        end
    end

    // Raise the ECC clear pulse for one clock after a write with the trigger bit set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecc_q <= 1'b0;
        end else begin
            ecc_q <= wr_en & wdata[BIT_ECC];
        end
    end

    // Assemble the read-back value; the trigger bit always reads 0.
    always_comb begin
        rd_value                        = '0;
        rd_value[BIT_EN]                = en_q;
        rd_value[BIT_CE_N]              = ce_n_q;
        rd_value[LSB_SETUP +: TIM_W]    = tim_q.setup;
        rd_value[LSB_PULSE +: TIM_W]    = tim_q.pulse;
        rd_value[LSB_HOLD  +: TIM_W]    = tim_q.hold;
    end

    logic unused_wbits;
    assign unused_wbits = ^{wdata[DATA_W-1:16], wdata[14:13], wdata[7], wdata[3]};

    assign en        = en_q;
    assign ce_n      = ce_n_q;
    assign timing    = tim_q;
    assign ecc_pulse = ecc_q;

endmodule

// File: rtl/nand_host_dec.sv
// Host access decoder. It accepts a request only on a clock where no flash
// cycle is running. It classifies the access by offset and decides whether
// a flash cycle starts and which latch signals that cycle carries.
// Assumes the host holds the request signals steady for the clock it is sampled.
module nand_host_dec
    import nand_flash_pkg::*;
(
    input  logic             req,
    input  logic             we,
    input  logic [OFS_W-1:0] addr,
    input  logic             busy,
    input  logic             en,
    output logic             accept,
    output logic             cfg_wr,
    output logic             rd_cfg,
    output logic             rd_stat,
    output logic             start,
    output logic             start_rd,
    output logic             start_cle,
    output logic             start_ale
);

    logic hit_cmd;
    logic hit_adr;
    logic hit_dat;

    // Decode the offset and qualify it with acceptance and the enable bit.
    always_comb begin
        accept    = req & ~busy;
        hit_cmd   = (addr == OFS_CMD);
        hit_adr   = (addr == OFS_ADR);
        hit_dat   = (addr == OFS_DAT);
        cfg_wr    = accept &  we & (addr == OFS_CFG);
        rd_cfg    = accept & ~we & (addr == OFS_CFG);
        rd_stat   = accept & ~we & (addr == OFS_STAT);
        start     = accept & en & ((we & (hit_cmd | hit_adr | hit_dat)) | (~we & hit_dat));
        start_rd  = ~we & hit_dat;
        start_cle = we & hit_cmd;
        start_ale = we & hit_adr;
    end

endmodule

// File: rtl/nand_cycle_seq.sv
// Flash cycle sequencer. It runs the setup, strobe and hold phases with
// the clock counts taken from the timing fields (each value + 1). It drives
// the latch, strobe and data-enable pins and captures the read byte on the
// last strobe clock. The timing fields must not change during a cycle;
// the host port guarantees this by stalling.
module nand_cycle_seq
    import nand_flash_pkg::*;
#(
    parameter int FLASH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_rd,
    input  logic               start_cle,
    input  logic               start_ale,
    input  logic [FLASH_W-1:0] wbyte,
    input  timing_t            timing,
    input  logic [FLASH_W-1:0] dq_i,
    output logic               busy,
    output logic               rd_done,
    output logic [FLASH_W-1:0] rd_byte,
    output logic               cle,
    output logic               ale,
    output logic               we_n,
    output logic               re_n,
    output logic               dq_oe,
    output logic [FLASH_W-1:0] dq_o
);

    phase_e             ph_q;
    logic [TIM_W-1:0]   cnt_q;
    logic               rd_q;
    logic               cle_q;
    logic               ale_q;
    logic [FLASH_W-1:0] byte_q;
    logic [FLASH_W-1:0] cap_q;
    logic               last_clk;

    assign last_clk = (cnt_q == '0);

    // Advance through the phases, reloading the counter at each phase change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        ph_q  <= PH_SETUP;
                        cnt_q <= timing.setup;
                    end
                end
                PH_SETUP: begin
                    if (last_clk) begin
                        ph_q  <= PH_STROBE;
                        cnt_q <= timing.pulse;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (last_clk) begin
                        ph_q  <= PH_HOLD;
                        cnt_q <= timing.hold;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (last_clk) begin
                        ph_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Latch the cycle kind and the write byte when a cycle starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            cle_q  <= 1'b0;
            ale_q  <= 1'b0;
            byte_q <= '0;
        end else if (start && ph_q == PH_IDLE) begin
            rd_q   <= start_rd;
            cle_q  <= start_cle;
            ale_q  <= start_ale;
            byte_q <= wbyte;
        end
    end

    // Capture the flash byte on the last clock of a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (ph_q == PH_STROBE && last_clk && rd_q) begin
            cap_q <= dq_i;
        end
    end

    // Drive the pins from the phase and the latched cycle kind.
    always_comb begin
        busy    = (ph_q != PH_IDLE);
        rd_done = (ph_q == PH_HOLD) && last_clk && rd_q;
        cle     = busy & cle_q;
        ale     = busy & ale_q;
        we_n    = ~((ph_q == PH_STROBE) & ~rd_q);
        re_n    = ~((ph_q == PH_STROBE) &  rd_q);
        dq_oe   = busy & ~rd_q;
        dq_o    = byte_q;
        rd_byte = cap_q;
    end

endmodule

// File: rtl/nand_flash_ctrl.sv
// Top level of the NAND flash controller. It connects the host decoder,
// the configuration register and the cycle sequencer, and owns the
// registered host read-data path. Assumes DATA_W > 16 and FLASH_W <= DATA_W.
module nand_flash_ctrl
    import nand_flash_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int FLASH_W = 8,
    parameter int ADDR_W  = OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               host_wait,
    output logic               fl_ce_n,
    output logic               fl_cle,
    output logic               fl_ale,
    output logic               fl_we_n,
    output logic               fl_re_n,
    output logic [FLASH_W-1:0] fl_dq_o,
    output logic               fl_dq_oe,
    input  logic [FLASH_W-1:0] fl_dq_i,
    input  logic               fl_rdy,
    output logic               ecc_clear
);

    localparam int PAD_W = DATA_W - FLASH_W;

    logic               acc;
    logic               cfg_wr;
    logic               rd_cfg;
    logic               rd_stat;
    logic               start;
    logic               start_rd;
    logic               start_cle;
    logic               start_ale;
    logic               cfg_en;
    logic               seq_busy;
    logic               rd_done;
    logic [FLASH_W-1:0] rd_byte;
    logic [DATA_W-1:0]  cfg_value;
    logic [DATA_W-1:0]  rdata_q;
    timing_t            timing;

    nand_host_dec u_dec (
        .req       (host_req),
        .we        (host_we),
        .addr      (host_addr),
        .busy      (seq_busy),
        .en        (cfg_en),
        .accept    (acc),
        .cfg_wr    (cfg_wr),
        .rd_cfg    (rd_cfg),
        .rd_stat   (rd_stat),
        .start     (start),
        .start_rd  (start_rd),
        .start_cle (start_cle),
        .start_ale (start_ale)
    );

    nand_cfg_regs #(
        .DATA_W (DATA_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr),
        .wdata     (host_wdata),
        .en        (cfg_en),
        .ce_n      (fl_ce_n),
        .timing    (timing),
        .ecc_pulse (ecc_clear),
        .rd_value  (cfg_value)
    );

    nand_cycle_seq #(
        .FLASH_W (FLASH_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_rd  (start_rd),
        .start_cle (start_cle),
        .start_ale (start_ale),
        .wbyte     (host_wdata[FLASH_W-1:0]),
        .timing    (timing),
        .dq_i      (fl_dq_i),
        .busy      (seq_busy),
        .rd_done   (rd_done),
        .rd_byte   (rd_byte),
        .cle       (fl_cle),
        .ale       (fl_ale),
        .we_n      (fl_we_n),
        .re_n      (fl_re_n),
        .dq_oe     (fl_dq_oe),
        .dq_o      (fl_dq_o)
    );

    // Update the host read data on an accepted read or at the end of a flash read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_done) begin
            rdata_q <= {{PAD_W{1'b0}}, rd_byte};
        end else if (acc && !host_we) begin
            if (rd_cfg) begin
                rdata_q <= cfg_value;
            end else if (rd_stat) begin
                rdata_q <= {{(DATA_W-1){1'b0}}, fl_rdy};
            end else begin
                rdata_q <= '0;
            end
        end
    end

    assign host_rdata = rdata_q;
    assign host_wait  = seq_busy;

endmodule

// File: rtl/nand_flash_ctrl_chk.sv
// Protocol checker for the NAND flash controller, bound to the top module.
// It watches the pins and the enable state and reports rule violations.
module nand_flash_ctrl_chk #(
    parameter int FLASH_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_wait,
    input logic               cfg_en,
    input logic               fl_cle,
    input logic               fl_ale,
    input logic               fl_we_n,
    input logic               fl_re_n,
    input logic               fl_dq_oe,
    input logic [FLASH_W-1:0] fl_dq_o,
    input logic               ecc_clear
);

    AST_LATCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_cle && fl_ale)); // R2

    AST_LATCH_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wait && $past(host_wait)) |-> ($stable(fl_cle) && $stable(fl_ale))); // R3

    AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wait |-> (fl_we_n && fl_re_n && !fl_cle && !fl_ale && !fl_dq_oe)); // R4

    AST_CYCLE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_wait) |-> $past(cfg_en)); // R5

    AST_ECC_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_clear |=> !ecc_clear); // R7

    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_re_n |-> (!fl_dq_oe && !fl_cle && !fl_ale)); // R8

    AST_STROBE_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n || !fl_re_n) |-> host_wait); // R10

    AST_WRITE_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_dq_oe && $past(fl_dq_oe)) |-> $stable(fl_dq_o)); // R11

endmodule

bind nand_flash_ctrl nand_flash_ctrl_chk #(.FLASH_W(FLASH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wait (host_wait),
    .cfg_en    (cfg_en),
    .fl_cle    (fl_cle),
    .fl_ale    (fl_ale),
    .fl_we_n   (fl_we_n),
    .fl_re_n   (fl_re_n),
    .fl_dq_oe  (fl_dq_oe),
    .fl_dq_o   (fl_dq_o),
    .ecc_clear (ecc_clear)
);

// File: tb/nand_flash_ctrl_tb.sv
// Scoreboard bench: driver tasks queue the expected flash cycles, and a
// monitor measures each cycle on the pins and compares it with the queue.
module nand_flash_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_wait;
    logic        fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe, ecc_clear;
    logic [7:0]  fl_dq_o;
    logic [7:0]  fl_dq_i = '0;
    logic        fl_rdy = 1'b1;

    int checks = 0;
    int errors = 0;

    // kind: 0 command, 1 address, 2 data write, 3 data read
    typedef struct {
        int       kind;
        logic [7:0] d;
        int       s;
        int       p;
        int       h;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    nand_flash_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_wait(host_wait), .fl_ce_n(fl_ce_n), .fl_cle(fl_cle), .fl_ale(fl_ale),
        .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe),
        .fl_dq_i(fl_dq_i), .fl_rdy(fl_rdy), .ecc_clear(ecc_clear)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Flash model: during a read strobe present base + number of low clocks so far.
    logic [7:0] rd_base = 8'h40;
    int         low_cnt = 0;
    always @(negedge clk) begin
        if (!fl_re_n) begin
            low_cnt = low_cnt + 1;
            fl_dq_i = rd_base + 8'(low_cnt);
        end else begin
            low_cnt = 0;
        end
    end

    // Monitor: measure phase lengths and pin values of each flash cycle.
    int         m_s = 0, m_p = 0, m_h = 0;
    bit         m_in = 0, m_seen = 0, m_rd = 0, m_cle = 0, m_ale = 0, m_oe = 0;
    logic [7:0] m_d = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (host_wait) begin
                m_in = 1;
                if (!fl_we_n || !fl_re_n) begin
                    m_p++; m_seen = 1; m_rd = !fl_re_n;
                    m_cle = fl_cle; m_ale = fl_ale; m_oe = fl_dq_oe; m_d = fl_dq_o;
                end else if (!m_seen) begin
                    m_s++;
                end else begin
                    m_h++;
                end
            end else if (m_in) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R10 actual=unexpected flash cycle expected=none");
                end else begin
                    exp_t e;
                    int   k;
                    e = exp_q.pop_front();
                    if (m_rd) k = (!m_cle && !m_ale && !m_oe) ? 3 : 9;
                    else if (m_cle && !m_ale && m_oe) k = 0;
                    else if (m_ale && !m_cle && m_oe) k = 1;
                    else if (!m_cle && !m_ale && m_oe) k = 2;
                    else k = 9;
                    case (e.kind)
                        0: check("R2 cycle kind", 32'(k), 32'(e.kind));
                        1: check("R3 cycle kind", 32'(k), 32'(e.kind));
                        2: check("R11 cycle kind", 32'(k), 32'(e.kind));
                        default: check("R8 cycle kind", 32'(k), 32'(e.kind));
                    endcase
                    if (e.kind != 3) check("R11 driven byte", {24'h0, m_d}, {24'h0, e.d});
                    check("R4 setup/strobe/hold clocks", {8'(m_s), 8'(m_p), 8'(m_h)},
                          {8'(e.s), 8'(e.p), 8'(e.h)});
                end
                m_in = 0; m_seen = 0; m_s = 0; m_p = 0; m_h = 0;
            end
        end
    end

    int cur_s = 4, cur_p = 8, cur_h = 8;

    function automatic logic [31:0] mk_cfg(bit en, bit ecc, bit ce_n, int s, int p, int h);
        return (32'(en) << 15) | (32'(ecc) << 12) | (32'(ce_n) << 11)
             | (32'(s - 1) << 8) | (32'(p - 1) << 4) | 32'(h - 1);
    endfunction

    task automatic bus_acc(input logic [4:0] a, input logic w, input logic [31:0] d);
        @(negedge clk);
        while (host_wait) @(negedge clk);
        host_req = 1'b1; host_we = w; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (host_wait) @(negedge clk);
    endtask

    task automatic set_timing(input int s, input int p, input int h);
        cur_s = s; cur_p = p; cur_h = h;
        bus_acc(5'h00, 1'b1, mk_cfg(1, 0, 0, s, p, h));
    endtask

    task automatic flash_wr(input int kind, input logic [7:0] d);
        exp_t e;
        e.kind = kind; e.d = d; e.s = cur_s; e.p = cur_p; e.h = cur_h;
        exp_q.push_back(e);
        bus_acc(kind == 0 ? 5'h04 : (kind == 1 ? 5'h08 : 5'h0C), 1'b1, {24'hABCDEF, d});
        wait_idle();
    endtask

    task automatic flash_rd(input logic [7:0] base);
        exp_t e;
        e.kind = 3; e.d = '0; e.s = cur_s; e.p = cur_p; e.h = cur_h;
        exp_q.push_back(e);
        rd_base = base;
        bus_acc(5'h0C, 1'b0, '0);
        wait_idle();
        check("R8 read byte", host_rdata, {24'h0, base + 8'(cur_p)});
    endtask

    task automatic run_set();
        flash_wr(0, 8'h70);
        flash_wr(1, 8'h12);
        flash_wr(2, 8'hA5);
        flash_rd(8'h30);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pins", {26'h0, fl_ce_n, fl_we_n, fl_re_n, fl_cle, fl_ale, fl_dq_oe},
              {26'h0, 6'b111000});
        check("R1 wait/ecc", {30'h0, host_wait, ecc_clear}, 32'h0);
        check("R1 rdata", host_rdata, 32'h0);
        bus_acc(5'h00, 1'b0, '0);
        check("R1 config", host_rdata, 32'h0000_0B77);

        // R9 status
        fl_rdy = 1'b1;
        bus_acc(5'h10, 1'b0, '0);
        check("R9 ready", host_rdata, 32'h1);
        fl_rdy = 1'b0;
        bus_acc(5'h10, 1'b0, '0);
        check("R9 busy", host_rdata, 32'h0);
        fl_rdy = 1'b1;

        // R5 disabled: no cycles
        bus_acc(5'h04, 1'b1, 32'h0000_00FF);
        check("R5 wait after cmd", {31'h0, host_wait}, 32'h0);
        bus_acc(5'h0C, 1'b1, 32'h0000_0011);
        repeat (3) @(negedge clk);
        check("R5 wait after data", {31'h0, host_wait}, 32'h0);
        bus_acc(5'h0C, 1'b0, '0);
        check("R5 data read", {host_rdata[30:0], host_wait}, 32'h0);

        // R6 chip enable
        bus_acc(5'h00, 1'b1, mk_cfg(1, 0, 0, 4, 8, 8));
        check("R6 ce asserted", {31'h0, fl_ce_n}, 32'h0);
        bus_acc(5'h00, 1'b1, mk_cfg(1, 0, 1, 4, 8, 8));
        check("R6 ce released", {31'h0, fl_ce_n}, 32'h1);

        // R7 ECC clear pulse
        bus_acc(5'h00, 1'b1, mk_cfg(1, 1, 0, 4, 8, 8));
        check("R7 pulse high", {31'h0, ecc_clear}, 32'h1);
        @(negedge clk);
        check("R7 pulse gone", {31'h0, ecc_clear}, 32'h0);
        bus_acc(5'h00, 1'b0, '0);
        check("R7 readback", host_rdata, mk_cfg(1, 0, 0, 4, 8, 8));

        // R2 R3 R4 R8 R11 under three timing sets
        set_timing(4, 8, 8);
        run_set();
        set_timing(1, 1, 1);
        run_set();
        set_timing(3, 2, 4);
        run_set();
        set_timing(8, 1, 2);
        flash_rd(8'hF0);

        // R10 request during a running cycle is ignored
        set_timing(2, 3, 2);
        begin
            exp_t e;
            e.kind = 0; e.d = 8'h90; e.s = cur_s; e.p = cur_p; e.h = cur_h;
            exp_q.push_back(e);
        end
        bus_acc(5'h04, 1'b1, 32'h90);
        host_req = 1'b1; host_we = 1'b1; host_addr = 5'h0C; host_wdata = 32'h55;
        repeat (2) @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);
        check("R10 no extra cycle", {31'h0, host_wait}, 32'h0);
        check("R10 queue drained", 32'(exp_q.size()), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule